// File: doc/BRIEF.md
# Packet-to-AHB Master Bridge

The bridge turns command packets from a remote host into single-word AHB master transfers. Each packet arrives on a valid/ready stream as three 32-bit words presented in parallel: a command kind, a byte address and a data word. Write commands are posted into a small circular queue and drained in arrival order by a master sequencer. A read command is latched into a holding register in the cycle it is offered, so the input handshake never waits on the bus. The read's result goes back to the host as a response packet on a second valid/ready stream.

The sequencer requests the bus, waits for grant and a ready bus, and issues one NONSEQ word transfer per command. Queued writes always go to the bus before a held read. While a read is outstanding, the input accepts nothing further. The host therefore stays stalled until the read's response has been taken, and program order is preserved without any address comparison.

Top module: `pkt_ahb_bridge`

## Requirements
- R1: Command kind codes are 1 for read and 2 for write. A response carries kind code 3 (read acknowledge), the read's byte address and the captured read data.
- R2: While reset is low, hbusreq is 0, htrans is IDLE (2'b00) and rsp_valid is 0. The queue is empty and no read is held, so cmd_ready is 1.
- R3: Every transfer starts with hbusreq high. An address phase (htrans NONSEQ, 2'b10) is driven only while hgrant is high, and it is taken only on a cycle with hready high. Every transfer is a single word: hsize 3'b010 and hburst 3'b000.
- R4: A write's data phase drives the packet's data word on hwdata and holds it through wait states until hready is high. A write never produces a response.
- R5: A read's data is captured from hrdata in the data-phase cycle with hready high. The response stays valid with stable fields until rsp_ready is high.
- R6: The write queue holds QDEPTH entries (default 4) and issues them in arrival order. When it is full, cmd_ready is low for a write command, and no command is lost.
- R7: A push and a pop of the write queue in the same cycle leave its occupancy unchanged, and neither loses nor repeats an entry.
- R8: A read is accepted at once when no read is held. After that, cmd_ready stays low for every command until the response handshake completes. The read reaches the bus only after every write accepted before it.
- R9: A command of any other kind is accepted and has no effect: no bus request, no transfer and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command packet offered |
| cmd_ready | output | 1 | Command packet accepted this cycle when valid |
| cmd_kind | input | 32 | Command kind word |
| cmd_addr | input | AW | Command byte address |
| cmd_data | input | DW | Command data word |
| rsp_valid | output | 1 | Response packet offered |
| rsp_ready | input | 1 | Host takes the response |
| rsp_kind | output | 32 | Response kind (3 when valid) |
| rsp_addr | output | AW | Address of the read being answered |
| rsp_data | output | DW | Read data |
| hbusreq | output | 1 | Bus request |
| hgrant | input | 1 | Bus grant |
| htrans | output | 2 | Transfer type |
| haddr | output | AW | Transfer address |
| hwrite | output | 1 | Transfer direction, 1 for write |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type |
| hwdata | output | DW | Write data |
| hready | input | 1 | Bus ready |
| hrdata | input | DW | Read data |

## Verification
Two things can fall in the same cycle: a push of a new write into the queue and a pop of the queue by a completing write data phase. The bench provokes this by streaming writes back-to-back into an empty queue while the bus is granted, so arrivals continue while the first drains complete. It counts the cycles in which both happen and requires that count to be non-zero. It judges the outcome three ways: cmd_ready is predicted every cycle from a model occupancy, the bus write order is compared against arrival order, and the final contents of the bench's memory are compared word by word. A read that is latched while writes are still queued is handled similarly: its response must carry the data of the last write to that address.

// File: rtl/pkt_ahb_pkg.sv
package pkt_ahb_pkg;
  localparam logic [31:0] KIND_RD   = 32'd1;
  localparam logic [31:0] KIND_WR   = 32'd2;
  localparam logic [31:0] KIND_RACK = 32'd3;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [2:0] SZ_WORD   = 3'b010;
  localparam logic [2:0] BU_SINGLE = 3'b000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WDATA,
    ST_RDATA,
    ST_RACK
  } mst_state_e;
endpackage

// File: rtl/pkt_wr_fifo.sv
module pkt_wr_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 64,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] level_q, level_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop) begin
      rd_ptr_d = (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push, pop})
      2'b10:   level_d = level_q + 1'b1;
      2'b01:   level_d = level_q - 1'b1;
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slot_q[wr_ptr_q] <= push_data;
    end
  end

  assign head  = slot_q[rd_ptr_q];
  assign level = level_q;
  assign full  = (level_q == LW'(DEPTH));
  assign empty = (level_q == '0);
endmodule

// File: rtl/pkt_cmd_rx.sv
module pkt_cmd_rx
  import pkt_ahb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [31:0]   cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic          q_full,
  input  logic          rd_done,
  output logic          cmd_ready,
  output logic          q_push,
  output logic          rd_pend,
  output logic [AW-1:0] rd_addr
);
  logic          is_wr, is_rd, take, rd_load;
  logic          rd_pend_q, rd_pend_d;
  logic [AW-1:0] rd_addr_q;

  assign is_wr     = (cmd_kind == KIND_WR);
  assign is_rd     = (cmd_kind == KIND_RD);
  assign cmd_ready = !rd_pend_q && !(is_wr && q_full);
  assign take      = cmd_valid && cmd_ready;
  assign q_push    = take && is_wr;
  assign rd_load   = take && is_rd;

  always_comb begin
    rd_pend_d = rd_pend_q;
    if (rd_load) begin
      rd_pend_d = 1'b1;
    end else if (rd_done) begin
      rd_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
    end else begin
      rd_pend_q <= rd_pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_load) begin
      rd_addr_q <= cmd_addr;
    end
  end

  assign rd_pend = rd_pend_q;
  assign rd_addr = rd_addr_q;
endmodule

// File: rtl/pkt_ahb_mst_fsm.sv
module pkt_ahb_mst_fsm
  import pkt_ahb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_empty,
  input  logic [AW-1:0] q_addr,
  input  logic [DW-1:0] q_data,
  input  logic          rd_pend,
  input  logic [AW-1:0] rd_addr,
  input  logic          hgrant,
  input  logic          hready,
  input  logic [DW-1:0] hrdata,
  input  logic          rsp_ready,
  output logic          q_pop,
  output logic          rd_done,
  output logic          hbusreq,
  output logic [1:0]    htrans,
  output logic [AW-1:0] haddr,
  output logic          hwrite,
  output logic [DW-1:0] hwdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_kind,
  output logic [AW-1:0] rsp_addr,
  output logic [DW-1:0] rsp_data
);
  mst_state_e    state_q, state_d;
  logic          op_wr_q, op_wr_d;
  logic          cap_en;
  logic [AW-1:0] rsp_addr_q;
  logic [DW-1:0] rsp_data_q;

  always_comb begin
    state_d   = state_q;
    op_wr_d   = op_wr_q;
    cap_en    = 1'b0;
    q_pop     = 1'b0;
    rd_done   = 1'b0;
    hbusreq   = 1'b0;
    htrans    = TR_IDLE;
    haddr     = '0;
    hwrite    = 1'b0;
    hwdata    = '0;
    rsp_valid = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!q_empty) begin
          state_d = ST_REQ;
          op_wr_d = 1'b1;
        end else if (rd_pend) begin
          state_d = ST_REQ;
          op_wr_d = 1'b0;
        end
      end
      ST_REQ: begin
        hbusreq = 1'b1;
        haddr   = op_wr_q ? q_addr : rd_addr;
        hwrite  = op_wr_q;
        if (hgrant) begin
          htrans = TR_NONSEQ;
          if (hready) begin
            state_d = op_wr_q ? ST_WDATA : ST_RDATA;
          end
        end
      end
      ST_WDATA: begin
        hwdata = q_data;
        if (hready) begin
          q_pop   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_RDATA: begin
        if (hready) begin
          cap_en  = 1'b1;
          state_d = ST_RACK;
        end
      end
      ST_RACK: begin
        rsp_valid = 1'b1;
        if (rsp_ready) begin
          rd_done = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      op_wr_q <= op_wr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      rsp_data_q <= hrdata;
      rsp_addr_q <= rd_addr;
    end
  end

  assign rsp_kind = rsp_valid ? KIND_RACK : '0;
  assign rsp_addr = rsp_addr_q;
  assign rsp_data = rsp_data_q;
endmodule

// File: rtl/pkt_ahb_bridge.sv
module pkt_ahb_bridge
  import pkt_ahb_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int QDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [31:0]   cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_kind,
  output logic [AW-1:0] rsp_addr,
  output logic [DW-1:0] rsp_data,
  output logic          hbusreq,
  input  logic          hgrant,
  output logic [1:0]    htrans,
  output logic [AW-1:0] haddr,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic [DW-1:0] hwdata,
  input  logic          hready,
  input  logic [DW-1:0] hrdata
);
  localparam int EW = AW + DW;
  localparam int LW = $clog2(QDEPTH + 1);

  logic          q_push, q_pop, q_full, q_empty;
  logic [LW-1:0] q_level;
  logic [EW-1:0] q_head;
  logic          rd_pend, rd_done;
  logic [AW-1:0] rd_addr;

  pkt_cmd_rx #(.AW(AW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .q_full    (q_full),
    .rd_done   (rd_done),
    .cmd_ready (cmd_ready),
    .q_push    (q_push),
    .rd_pend   (rd_pend),
    .rd_addr   (rd_addr)
  );

  pkt_wr_fifo #(.DEPTH(QDEPTH), .W(EW)) u_wq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data ({cmd_addr, cmd_data}),
    .pop       (q_pop),
    .head      (q_head),
    .level     (q_level),
    .full      (q_full),
    .empty     (q_empty)
  );

  pkt_ahb_mst_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_empty   (q_empty),
    .q_addr    (q_head[EW-1:DW]),
    .q_data    (q_head[DW-1:0]),
    .rd_pend   (rd_pend),
    .rd_addr   (rd_addr),
    .hgrant    (hgrant),
    .hready    (hready),
    .hrdata    (hrdata),
    .rsp_ready (rsp_ready),
    .q_pop     (q_pop),
    .rd_done   (rd_done),
    .hbusreq   (hbusreq),
    .htrans    (htrans),
    .haddr     (haddr),
    .hwrite    (hwrite),
    .hwdata    (hwdata),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .rsp_addr  (rsp_addr),
    .rsp_data  (rsp_data)
  );

  assign hsize  = SZ_WORD;
  assign hburst = BU_SINGLE;
endmodule

// File: rtl/pkt_ahb_bridge_chk.sv
module pkt_ahb_bridge_chk
  import pkt_ahb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [31:0]   cmd_kind,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_addr,
  input logic [DW-1:0] rsp_data,
  input logic          hbusreq,
  input logic          hgrant,
  input logic [1:0]    htrans,
  input logic [LW-1:0] q_level,
  input logic          q_push,
  input logic          q_pop
);
  assert_nonseq_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == TR_NONSEQ) |-> (hgrant && hbusreq));

  assert_trans_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == TR_IDLE) || (htrans == TR_NONSEQ));

  assert_rsp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_addr)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= LW'(DEPTH));

  assert_full_blocks_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_level == LW'(DEPTH)) |-> !q_push);

  assert_atomic_pushpop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && q_pop) |=> (q_level == $past(q_level)));

  assert_read_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == KIND_RD) |=> !cmd_ready);
endmodule

bind pkt_ahb_bridge pkt_ahb_bridge_chk #(.AW(AW), .DW(DW), .DEPTH(QDEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_kind  (cmd_kind),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr  (rsp_addr),
  .rsp_data  (rsp_data),
  .hbusreq   (hbusreq),
  .hgrant    (hgrant),
  .htrans    (htrans),
  .q_level   (q_level),
  .q_push    (q_push),
  .q_pop     (q_pop)
);

// File: tb/test_pkt_ahb_bridge.sv
module test_pkt_ahb_bridge;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam logic [31:0] K_RD = 32'd1;
  localparam logic [31:0] K_WR = 32'd2;
  localparam logic [31:0] K_ACK = 32'd3;

  logic clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  logic        rst_n;
  logic        cmd_valid, cmd_ready;
  logic [31:0] cmd_kind, cmd_addr, cmd_data;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_kind, rsp_addr, rsp_data;
  logic        hbusreq, hgrant, hwrite, hready;
  logic [1:0]  htrans;
  logic [31:0] haddr, hwdata, hrdata;
  logic [2:0]  hsize, hburst;

  pkt_ahb_bridge #(.AW(32), .DW(32), .QDEPTH(DEPTH)) i_pkt_ahb_bridge (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .hbusreq(hbusreq), .hgrant(hgrant), .htrans(htrans), .haddr(haddr),
    .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
    .hready(hready), .hrdata(hrdata)
  );

  int n_chk = 0;
  int n_err = 0;

  // bench memory slave and reference memory
  logic [31:0] slv_mem [16];
  logic [31:0] ref_mem [16];
  logic        dp_v, dp_w, pn_dp_v, pn_dp_w, pn_we;
  logic [3:0]  dp_a, pn_dp_a, pn_wa;
  logic [31:0] pn_wd, cur_wd;
  assign hrdata = slv_mem[dp_a];

  logic [31:0] cq_k[$], cq_a[$], cq_d[$];
  bit          eo_w[$];
  logic [31:0] eo_a[$], eo_d[$];
  logic [31:0] er_a[$], er_d[$];
  int  m_cnt = 0;
  bit  m_rd = 0;
  int  g_mode = 0, r_mode = 0, p_mode = 0;
  int  cyc = 0;
  int  both_cnt = 0;
  bit  saw_req = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit pat(input int mode);
    case (mode)
      0: pat = 1'b1;
      1: pat = 1'b0;
      2: pat = (cyc % 2) == 0;
      default: pat = (cyc % 3) != 0;
    endcase
  endfunction

  task automatic send(input logic [31:0] k, input logic [31:0] a, input logic [31:0] d);
    cq_k.push_back(k); cq_a.push_back(a); cq_d.push_back(d);
  endtask

  task automatic step();
    bit exp_rdy, pushed, popped;
    @(negedge clk);
    dp_v = pn_dp_v; dp_w = pn_dp_w; dp_a = pn_dp_a;
    if (pn_we) slv_mem[pn_wa] = pn_wd;
    pn_we = 1'b0;
    cyc++;
    hgrant = pat(g_mode);
    hready = pat(r_mode);
    rsp_ready = pat(p_mode);
    if (cq_k.size() != 0) begin
      cmd_valid = 1'b1; cmd_kind = cq_k[0]; cmd_addr = cq_a[0]; cmd_data = cq_d[0];
    end else begin
      cmd_valid = 1'b0;
    end
    #1;
    if (hbusreq) saw_req = 1'b1;
    pushed = 1'b0;
    popped = 1'b0;
    if (cmd_valid) begin
      exp_rdy = !m_rd && !(cmd_kind == K_WR && m_cnt == DEPTH);
      if (cmd_kind == K_WR && m_cnt == DEPTH)
        chk(cmd_ready == exp_rdy, "R6", "cmd_ready with full queue", cmd_ready, exp_rdy);
      else
        chk(cmd_ready == exp_rdy, "R8", "cmd_ready", cmd_ready, exp_rdy);
      if (cmd_ready) begin
        void'(cq_k.pop_front()); void'(cq_a.pop_front()); void'(cq_d.pop_front());
        if (cmd_kind == K_WR) begin
          pushed = 1'b1;
          m_cnt++;
          ref_mem[cmd_addr[5:2]] = cmd_data;
          eo_w.push_back(1'b1); eo_a.push_back(cmd_addr); eo_d.push_back(cmd_data);
        end else if (cmd_kind == K_RD) begin
          m_rd = 1'b1;
          eo_w.push_back(1'b0); eo_a.push_back(cmd_addr); eo_d.push_back(32'h0);
          er_a.push_back(cmd_addr); er_d.push_back(ref_mem[cmd_addr[5:2]]);
        end
      end
    end
    if (htrans == 2'b10) begin
      chk(hgrant && hbusreq, "R3", "NONSEQ without grant/request", {hgrant, hbusreq}, 2'b11);
      if (hready) begin
        if (eo_a.size() == 0) begin
          chk(1'b0, "R9", "unexpected transfer", haddr, 32'h0);
        end else begin
          chk(hwrite == eo_w[0], "R6", "transfer direction order", hwrite, eo_w[0]);
          chk(haddr == eo_a[0], "R6", "transfer address order", haddr, eo_a[0]);
          chk(hsize == 3'b010 && hburst == 3'b000, "R3", "single word attributes",
              {hsize, hburst}, 6'b010000);
          cur_wd = eo_d[0];
          void'(eo_w.pop_front()); void'(eo_a.pop_front()); void'(eo_d.pop_front());
        end
      end
    end else begin
      chk(htrans == 2'b00, "R3", "htrans idle outside address phase", htrans, 2'b00);
    end
    if (dp_v && dp_w) begin
      chk(hwdata == cur_wd, "R4", "write data phase", hwdata, cur_wd);
    end
    if (rsp_valid && er_a.size() == 0) begin
      chk(1'b0, "R9", "unexpected response", rsp_addr, 32'h0);
    end
    if (rsp_valid && rsp_ready && er_a.size() != 0) begin
      chk(rsp_kind == K_ACK, "R1", "response kind", rsp_kind, K_ACK);
      chk(rsp_addr == er_a[0], "R1", "response address", rsp_addr, er_a[0]);
      chk(rsp_data == er_d[0], "R5", "response data", rsp_data, er_d[0]);
      void'(er_a.pop_front()); void'(er_d.pop_front());
      m_rd = 1'b0;
    end
    if (hready) begin
      if (dp_v && dp_w) begin
        pn_we = 1'b1; pn_wa = dp_a; pn_wd = hwdata;
        m_cnt--;
        popped = 1'b1;
      end
      pn_dp_v = (htrans == 2'b10);
      pn_dp_w = hwrite;
      pn_dp_a = haddr[5:2];
    end else begin
      pn_dp_v = dp_v; pn_dp_w = dp_w; pn_dp_a = dp_a;
    end
    if (pushed && popped) both_cnt++;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((cq_k.size() != 0 || eo_a.size() != 0 || er_a.size() != 0 || m_cnt != 0 || m_rd)
           && n < 3000) begin
      step();
      n++;
    end
    repeat (4) step();
    chk(n < 3000, req, "traffic drained", n, 3000);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      slv_mem[i] = 32'hA000_0000 + i;
      ref_mem[i] = 32'hA000_0000 + i;
    end
    dp_v = 0; dp_w = 0; dp_a = 0; pn_dp_v = 0; pn_dp_w = 0; pn_dp_a = 0;
    pn_we = 0; pn_wa = 0; pn_wd = 0; cur_wd = 0;
    cmd_valid = 0; cmd_kind = 0; cmd_addr = 0; cmd_data = 0;
    hgrant = 1; hready = 1; rsp_ready = 1;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R2: reset state
    chk(hbusreq == 1'b0, "R2", "hbusreq in reset", hbusreq, 1'b0);
    chk(htrans == 2'b00, "R2", "htrans in reset", htrans, 2'b00);
    chk(rsp_valid == 1'b0, "R2", "rsp_valid in reset", rsp_valid, 1'b0);
    chk(cmd_ready == 1'b1, "R2", "cmd_ready in reset", cmd_ready, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // R4 R5: write then read back, bus always ready
    send(K_WR, 32'h10, 32'h1234_5678);
    send(K_RD, 32'h10, 32'h0);
    send(K_RD, 32'h14, 32'h0);
    drain("R5");

    // R6 R3: grant withheld, queue fills, write stalls
    g_mode = 1;
    for (int i = 0; i < 6; i++) send(K_WR, 32'(i * 4), 32'hB000_0000 + 32'(i));
    repeat (12) step();
    chk(hbusreq == 1'b1, "R3", "request held while not granted", hbusreq, 1'b1);
    chk(htrans == 2'b00, "R3", "no address phase without grant", htrans, 2'b00);
    chk(cq_k.size() == 2, "R6", "two writes still held back", cq_k.size(), 2);
    g_mode = 0;
    drain("R6");

    // R7: back-to-back writes into an empty queue with the bus granted
    both_cnt = 0;
    for (int i = 0; i < 10; i++) send(K_WR, 32'((i % 8) * 4 + 32), 32'hC000_0000 + 32'(i));
    drain("R7");
    chk(both_cnt > 0, "R7", "same-cycle push and pop seen", both_cnt, 1);

    // R8: read latched behind queued writes to the same address
    g_mode = 1;
    send(K_WR, 32'h20, 32'hD000_0001);
    send(K_WR, 32'h20, 32'hD000_0002);
    send(K_WR, 32'h24, 32'hD000_0003);
    send(K_RD, 32'h20, 32'h0);
    send(K_WR, 32'h20, 32'hD000_0004);
    repeat (12) step();
    chk(cq_k.size() == 1, "R8", "command after read held back", cq_k.size(), 1);
    chk(cmd_ready == 1'b0, "R8", "input stalled while read held", cmd_ready, 1'b0);
    g_mode = 0;
    drain("R8");

    // mixed traffic with wait states, alternating grant and response back-pressure
    g_mode = 2; r_mode = 3; p_mode = 2;
    for (int i = 0; i < 14; i++) begin
      send(K_WR, 32'(((i * 5) % 16) * 4), 32'hE000_0000 + 32'(i * 7));
      if (i % 3 == 2) send(K_RD, 32'(((i * 5) % 16) * 4), 32'h0);
      if (i % 4 == 1) send(32'd7, 32'h4, 32'hFFFF_FFFF);
    end
    drain("R4");
    g_mode = 0; r_mode = 0; p_mode = 0;

    // R9: other kinds have no effect
    saw_req = 1'b0;
    send(32'd0, 32'h8, 32'h1);
    send(32'd7, 32'hC, 32'h2);
    send(32'hFFFF_FFFF, 32'h10, 32'h3);
    repeat (20) step();
    chk(saw_req == 1'b0, "R9", "no bus request for ignored kinds", saw_req, 1'b0);
    chk(cq_k.size() == 0, "R9", "ignored kinds accepted", cq_k.size(), 0);
    chk(rsp_valid == 1'b0, "R9", "no response for ignored kinds", rsp_valid, 1'b0);

    // R7 R4: final memory image
    for (int i = 0; i < 16; i++) begin
      chk(slv_mem[i] == ref_mem[i], "R7", "memory word after all writes", slv_mem[i], ref_mem[i]);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule